// File: doc/BRIEF.md
# UART Interrupt Prioritiser with Modem-Change Tracking

This block sits beside the serial datapaths of a UART. It gathers the interrupt sources into one identification code and one interrupt line. The sources are a received line error, the receive FIFO reaching its threshold, a character timeout, the transmit holding register going empty, and changes on the modem inputs. Software enables each category with one bit. It then reads the identification code to learn which pending source has the highest rank. Reading the code, the line status or the modem status has side effects, and these side effects are implemented here.

The four modem inputs are CTS, DSR, RI and DCD. Each passes through a synchroniser, and the block then latches change flags for them. A change on CTS, DSR or DCD sets a flag on either edge. RI sets its flag only when it goes from high to low. The block also drives the DTR and RTS requests as logical levels. Any pin polarity is handled outside this block.

Top module: `uart_irq_prio`

## Requirements
- R1: While rst_ni is low, id_o is 4'b0001, irq_o is 0 and msr_o is 8'h00.
- R2: Sources rank as follows, from highest to lowest, with the code each reports on id_o: line status (4'b0110), data available (4'b0100), character timeout (4'b1100), holding empty (4'b0010), modem status (4'b0000). With no enabled source pending, id_o is 4'b0001.
- R3: Each ier_i bit enables one category: bit 0 enables data available and timeout, bit 1 holding empty, bit 2 line status and bit 3 modem status. A source whose bit is clear appears on neither id_o nor irq_o, but it stays pending.
- R4: irq_o is 1 exactly when some enabled source is pending, which is exactly when id_o[0] is 0. It follows ier_i and the level inputs in the same cycle.
- R5: A one-cycle pulse on line_err_i latches the line-status source. lsr_rd_i clears it on the next edge. If a pulse and a read fall on the same edge, the source stays pending.
- R6: The data-available and timeout sources follow rx_thresh_i and rx_timeout_i directly, with no latching.
- R7: The holding-empty source becomes pending on the edge after thr_empty_i rises. It also becomes pending on the edge after ier_i[1] rises while thr_empty_i is high. It clears on the edge where id_rd_i is high while id_o shows 4'b0010, and on any edge where thr_empty_i is low.
- R8: An id_rd_i while id_o shows another source leaves a pending holding-empty source intact.
- R9: msr_o[4], msr_o[5], msr_o[6] and msr_o[7] show CTS, DSR, RI and DCD. Each of these bits reflects a pin change two edges after the change.
- R10: msr_o[0], msr_o[1] and msr_o[3] latch any change on CTS, DSR and DCD. msr_o[2] latches only a high-to-low change on RI. Each flag is set one edge after the matching level bit changes.
- R11: msr_rd_i clears all four change flags, and with them the modem source. A change detected on the same edge survives the read.
- R12: dtr_o equals mcr_i[0] and rts_o equals mcr_i[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Category enables |
| line_err_i | input | 1 | Pulse: a byte arrived with a line error |
| rx_thresh_i | input | 1 | Level: receive FIFO at or above threshold |
| rx_timeout_i | input | 1 | Level: character timeout pending |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| id_rd_i | input | 1 | Identification code read strobe |
| lsr_rd_i | input | 1 | Line status read strobe (plain or with a byte) |
| msr_rd_i | input | 1 | Modem status read strobe |
| cts_i | input | 1 | Clear-to-send, logical, asynchronous |
| dsr_i | input | 1 | Data-set-ready, logical, asynchronous |
| ri_i | input | 1 | Ring indicate, logical, asynchronous |
| dcd_i | input | 1 | Carrier detect, logical, asynchronous |
| mcr_i | input | 2 | Modem control request: bit 0 DTR, bit 1 RTS |
| id_o | output | 4 | Interrupt identification code |
| irq_o | output | 1 | Interrupt request |
| msr_o | output | 8 | Modem status: change flags [3:0], levels [7:4] |
| dtr_o | output | 1 | Data-terminal-ready, logical |
| rts_o | output | 1 | Request-to-send, logical |

## Verification
Two functions can land on the same clock edge: a source being set and a read that clears it. The bench provokes this twice. It raises line_err_i together with lsr_rd_i, and it times msr_rd_i so that it meets the edge on which a DCD change is latched. In both cases the expected result is that the new event survives. The bench judges this by checking that id_o still shows the source, and that msr_o carries only the new flag while the older one is gone. A further read then clears the source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MODEM = 4'b0000,
    ID_NONE  = 4'b0001,
    ID_THRE  = 4'b0010,
    ID_RDA   = 4'b0100,
    ID_LINE  = 4'b0110,
    ID_CTO   = 4'b1100
  } irq_id_e;

  localparam int IER_RX    = 0;
  localparam int IER_THRE  = 1;
  localparam int IER_LINE  = 2;
  localparam int IER_MODEM = 3;

  localparam int MODEM_W = 4;
  localparam int RI_BIT  = 2;
endpackage

// File: rtl/uart_modem_track.sv
module uart_modem_track
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODEM_W-1:0] modem_i,
  input  logic               rd_i,
  output logic [MODEM_W-1:0] level_o,
  output logic [MODEM_W-1:0] chg_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][MODEM_W-1:0] sync_q;
  logic [MODEM_W-1:0] prev_q, chg_q, det;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= modem_i;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  // RI flags only its trailing edge; the others flag either edge
  for (genvar b = 0; b < MODEM_W; b++) begin : g_det
    if (b == RI_BIT) begin : g_fall
      assign det[b] = prev_q[b] & ~sync_q[LAST][b];
    end else begin : g_any
      assign det[b] = prev_q[b] ^ sync_q[LAST][b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      chg_q  <= '0;
    end else begin
      prev_q <= sync_q[LAST];
      chg_q  <= (rd_i ? '0 : chg_q) | det;  // new change wins over read
    end
  end

  assign level_o = sync_q[LAST];
  assign chg_o   = chg_q;
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_err_i,
  input  logic lsr_rd_i,
  input  logic thr_empty_i,
  input  logic thre_en_i,
  input  logic id_rd_i,
  input  logic thre_shown_i,
  output logic line_pend_o,
  output logic thre_pend_o
);
  logic line_q, thre_q, thr_prev_q, en_prev_q;
  logic thre_set, thre_clr;

  assign thre_set = thr_empty_i & (~thr_prev_q | (thre_en_i & ~en_prev_q));
  assign thre_clr = (id_rd_i & thre_shown_i) | ~thr_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q     <= 1'b0;
      thre_q     <= 1'b0;
      thr_prev_q <= 1'b0;
      en_prev_q  <= 1'b0;
    end else begin
      line_q     <= line_err_i | (line_q & ~lsr_rd_i);
      thre_q     <= thre_set | (thre_q & ~thre_clr);
      thr_prev_q <= thr_empty_i;
      en_prev_q  <= thre_en_i;
    end
  end

  assign line_pend_o = line_q;
  assign thre_pend_o = thre_q;
endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
  import uart_irq_pkg::*;
(
  input  logic [4:0] pend_i,  // masked: {line, rda, cto, thre, modem}
  output logic [3:0] id_o
);
  irq_id_e id;

  always_comb begin
    if      (pend_i[4]) id = ID_LINE;
    else if (pend_i[3]) id = ID_RDA;
    else if (pend_i[2]) id = ID_CTO;
    else if (pend_i[1]) id = ID_THRE;
    else if (pend_i[0]) id = ID_MODEM;
    else                id = ID_NONE;
  end

  assign id_o = id;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] ier_i,
  input  logic       line_err_i,
  input  logic       rx_thresh_i,
  input  logic       rx_timeout_i,
  input  logic       thr_empty_i,
  input  logic       id_rd_i,
  input  logic       lsr_rd_i,
  input  logic       msr_rd_i,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic [1:0] mcr_i,
  output logic [3:0] id_o,
  output logic       irq_o,
  output logic [7:0] msr_o,
  output logic       dtr_o,
  output logic       rts_o
);
  logic [MODEM_W-1:0] lvl, chg;
  logic line_pend, thre_pend, modem_pend;
  logic [4:0] masked;

  uart_modem_track #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .modem_i ({dcd_i, ri_i, dsr_i, cts_i}),
    .rd_i    (msr_rd_i),
    .level_o (lvl),
    .chg_o   (chg)
  );

  uart_irq_src u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_err_i   (line_err_i),
    .lsr_rd_i     (lsr_rd_i),
    .thr_empty_i  (thr_empty_i),
    .thre_en_i    (ier_i[IER_THRE]),
    .id_rd_i      (id_rd_i),
    .thre_shown_i (id_o == ID_THRE),
    .line_pend_o  (line_pend),
    .thre_pend_o  (thre_pend)
  );

  assign modem_pend = |chg;

  assign masked = {line_pend    & ier_i[IER_LINE],
                   rx_thresh_i  & ier_i[IER_RX],
                   rx_timeout_i & ier_i[IER_RX],
                   thre_pend    & ier_i[IER_THRE],
                   modem_pend   & ier_i[IER_MODEM]};

  uart_irq_enc u_enc (
    .pend_i (masked),
    .id_o   (id_o)
  );

  assign irq_o = |masked;
  assign msr_o = {lvl, chg};
  assign dtr_o = mcr_i[0];
  assign rts_o = mcr_i[1];
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] ier_i,
  input logic       line_err_i,
  input logic       rx_thresh_i,
  input logic       id_rd_i,
  input logic       msr_rd_i,
  input logic [3:0] id_o,
  input logic       irq_o,
  input logic [7:0] msr_o
);
  p_irq_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (id_o != 4'b0001));

  p_no_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == 4'b0000) |-> !irq_o);

  p_rda_rank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i[0] && rx_thresh_i) |-> (id_o == 4'b0100 || id_o == 4'b0110));

  p_line_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_err_i && ier_i[2]) |=> (!ier_i[2] || id_o == 4'b0110));

  p_thre_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rd_i && id_o == 4'b0010 && $past(ier_i[1])) |=> (id_o != 4'b0010));

  p_ri_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(msr_o[6]) |=> msr_o[2]);

  p_ri_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(msr_o[6]) && !msr_o[2]) |=> !msr_o[2]);

  p_chg_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && $stable(msr_o[7:4])) |=> (msr_o[3:0] == 4'b0000));
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ier_i       (ier_i),
  .line_err_i  (line_err_i),
  .rx_thresh_i (rx_thresh_i),
  .id_rd_i     (id_rd_i),
  .msr_rd_i    (msr_rd_i),
  .id_o        (id_o),
  .irq_o       (irq_o),
  .msr_o       (msr_o)
);

// File: tb/uart_irq_prio_tb.sv
module uart_irq_prio_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] ier_i = '0;
  logic line_err_i = 0, rx_thresh_i = 0, rx_timeout_i = 0, thr_empty_i = 0;
  logic id_rd_i = 0, lsr_rd_i = 0, msr_rd_i = 0;
  logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic [1:0] mcr_i = '0;
  logic [3:0] id_o;
  logic irq_o;
  logic [7:0] msr_o;
  logic dtr_o, rts_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int kind;          // 0 id/irq, 1 msr, 2 {rts,dtr}
    logic [7:0] val;
    string req;
  } exp_t;
  exp_t q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  uart_irq_prio u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ier_i(ier_i),
    .line_err_i(line_err_i), .rx_thresh_i(rx_thresh_i),
    .rx_timeout_i(rx_timeout_i), .thr_empty_i(thr_empty_i),
    .id_rd_i(id_rd_i), .lsr_rd_i(lsr_rd_i), .msr_rd_i(msr_rd_i),
    .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
    .mcr_i(mcr_i), .id_o(id_o), .irq_o(irq_o), .msr_o(msr_o),
    .dtr_o(dtr_o), .rts_o(rts_o)
  );

  task automatic exp_id(input logic [3:0] v, input string r);
    q.push_back('{0, {4'b0000, v}, r});
  endtask
  task automatic exp_msr(input logic [7:0] v, input string r);
    q.push_back('{1, v, r});
  endtask
  task automatic exp_ctl(input logic [1:0] v, input string r);
    q.push_back('{2, {6'b0, v}, r});
  endtask
  task automatic tick();
    @(negedge clk_i);
  endtask

  // monitor: compare queued expectations shortly after each rising edge
  always @(posedge clk_i) begin
    exp_t e;
    #2;
    while (q.size() > 0) begin
      e = q.pop_front();
      total++;
      case (e.kind)
        0: begin
          if (id_o !== e.val[3:0]) begin
            bad++;
            $display("FAIL %s id_o actual=%b expected=%b", e.req, id_o, e.val[3:0]);
          end
          total++;
          if (irq_o !== ~e.val[0]) begin
            bad++;
            $display("FAIL R4 (%s) irq_o actual=%b expected=%b", e.req, irq_o, ~e.val[0]);
          end
        end
        1: if (msr_o !== e.val) begin
          bad++;
          $display("FAIL %s msr_o actual=%h expected=%h", e.req, msr_o, e.val);
        end
        default: if ({rts_o, dtr_o} !== e.val[1:0]) begin
          bad++;
          $display("FAIL %s rts,dtr actual=%b expected=%b", e.req, {rts_o, dtr_o}, e.val[1:0]);
        end
      endcase
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(); exp_id(4'b0001, "R1"); exp_msr(8'h00, "R1");
    tick(); rst_ni = 1; ier_i = 4'hF; exp_id(4'b0001, "R1");

    // R6 level sources, R2 data available over timeout
    tick(); rx_thresh_i = 1; exp_id(4'b0100, "R6");
    tick(); rx_timeout_i = 1; exp_id(4'b0100, "R2");
    tick(); rx_thresh_i = 0; exp_id(4'b1100, "R6");
    tick(); rx_timeout_i = 0; exp_id(4'b0001, "R6");

    // R5 line status latch, clear, coincident set and read
    tick(); rx_thresh_i = 1; line_err_i = 1; exp_id(4'b0110, "R5");
    tick(); line_err_i = 0; exp_id(4'b0110, "R5");
    tick(); lsr_rd_i = 1; exp_id(4'b0100, "R5");
    tick(); line_err_i = 1; exp_id(4'b0110, "R5");
    tick(); line_err_i = 0; exp_id(4'b0100, "R5");
    tick(); lsr_rd_i = 0; rx_thresh_i = 0; exp_id(4'b0001, "R5");

    // R3 enables mask but keep pending
    tick(); ier_i = 4'h0; line_err_i = 1; exp_id(4'b0001, "R3");
    tick(); line_err_i = 0; ier_i = 4'b0100; exp_id(4'b0110, "R3");
    tick(); lsr_rd_i = 1; exp_id(4'b0001, "R3");
    tick(); lsr_rd_i = 0; ier_i = 4'b0001; rx_timeout_i = 1; exp_id(4'b1100, "R3");
    tick(); ier_i = 4'b0000; exp_id(4'b0001, "R3");
    tick(); rx_timeout_i = 0; ier_i = 4'hF; exp_id(4'b0001, "R3");

    // R7 holding empty set / clear paths
    tick(); thr_empty_i = 1; exp_id(4'b0010, "R7");
    tick(); id_rd_i = 1; exp_id(4'b0001, "R7");
    tick(); id_rd_i = 0; exp_id(4'b0001, "R7");
    tick(); thr_empty_i = 0; exp_id(4'b0001, "R7");
    tick(); thr_empty_i = 1; exp_id(4'b0010, "R7");
    tick(); thr_empty_i = 0; exp_id(4'b0001, "R7");
    tick(); thr_empty_i = 1; exp_id(4'b0010, "R7");
    tick(); id_rd_i = 1; exp_id(4'b0001, "R7");
    tick(); id_rd_i = 0; ier_i = 4'b1101; exp_id(4'b0001, "R7");
    tick(); ier_i = 4'hF; exp_id(4'b0010, "R7");

    // R8 ID read during higher source keeps holding empty
    tick(); rx_thresh_i = 1; exp_id(4'b0100, "R2");
    tick(); id_rd_i = 1; exp_id(4'b0100, "R8");
    tick(); id_rd_i = 0; rx_thresh_i = 0; exp_id(4'b0010, "R8");
    tick(); id_rd_i = 1; exp_id(4'b0001, "R8");
    tick(); id_rd_i = 0;

    // R9 / R10 / R11 modem tracking
    tick(); cts_i = 1; exp_msr(8'h00, "R9");
    tick(); exp_msr(8'h10, "R9");
    tick(); exp_msr(8'h11, "R10"); exp_id(4'b0000, "R10");
    tick(); msr_rd_i = 1; exp_msr(8'h10, "R11"); exp_id(4'b0001, "R11");
    tick(); msr_rd_i = 0; ri_i = 1; exp_msr(8'h10, "R9");
    tick(); exp_msr(8'h50, "R9");
    tick(); exp_msr(8'h50, "R10"); exp_id(4'b0001, "R10");
    tick(); ri_i = 0; exp_msr(8'h50, "R10");
    tick(); exp_msr(8'h10, "R9");
    tick(); exp_msr(8'h14, "R10"); exp_id(4'b0000, "R10");
    tick(); msr_rd_i = 1; exp_msr(8'h10, "R11");
    tick(); msr_rd_i = 0; dcd_i = 1; exp_msr(8'h10, "R9");
    tick(); exp_msr(8'h90, "R9");
    tick(); msr_rd_i = 1; exp_msr(8'h98, "R11"); exp_id(4'b0000, "R11");
    tick(); msr_rd_i = 0; exp_msr(8'h98, "R11");
    tick(); msr_rd_i = 1; exp_msr(8'h90, "R11"); exp_id(4'b0001, "R11");
    tick(); msr_rd_i = 0; ier_i = 4'b0111; cts_i = 0; exp_msr(8'h90, "R9");
    tick(); exp_msr(8'h80, "R9");
    tick(); exp_msr(8'h81, "R10"); exp_id(4'b0001, "R3");
    tick(); ier_i = 4'hF; exp_id(4'b0000, "R3");
    tick(); msr_rd_i = 1; exp_msr(8'h80, "R11"); exp_id(4'b0001, "R11");
    tick(); msr_rd_i = 0; dsr_i = 1;
    tick();
    tick(); exp_msr(8'hA2, "R10"); exp_id(4'b0000, "R10");

    // R2 holding empty over modem, timeout over holding empty
    tick(); ier_i = 4'b1101; exp_id(4'b0000, "R2");
    tick(); ier_i = 4'hF; exp_id(4'b0010, "R2");
    tick(); id_rd_i = 1; exp_id(4'b0000, "R7");
    tick(); id_rd_i = 0; msr_rd_i = 1; exp_id(4'b0001, "R11");
    tick(); msr_rd_i = 0; ier_i = 4'b1101;
    tick(); ier_i = 4'hF; rx_timeout_i = 1; exp_id(4'b1100, "R2");
    tick(); rx_timeout_i = 0; exp_id(4'b0010, "R2");
    tick(); id_rd_i = 1; exp_id(4'b0001, "R7");
    tick(); id_rd_i = 0;

    // R12 modem control pass-through
    tick(); mcr_i = 2'b01; exp_ctl(2'b01, "R12");
    tick(); mcr_i = 2'b10; exp_ctl(2'b10, "R12");
    tick(); mcr_i = 2'b11; exp_ctl(2'b11, "R12");

    tick(); tick();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule